// File: doc/BRIEF.md
# Masked Compare-and-Swap Read-Modify-Write Engine

This block carries out one atomic read-modify-write on a simple master bus. A command supplies a target address, a compare value, a mask and a swap value. The engine requests the bus, locks it once granted, reads one word from the target and checks only the bits the mask selects against the compare value.

When those bits agree, the engine writes the word back. In the write, the selected bits come from the swap value and every other bit keeps the value that was read. When they disagree, no write cycle is issued. The lock is kept from the grant until the sequence ends, so no other master can touch the target between the read and the write.

Completion is reported with a one-cycle done pulse. With it come a success flag and the word originally read. A caller can use this for semaphores, bit-field claims or counters held in shared memory.

Top module: `masked_cas_engine`

## Requirements
- R1: During and after a synchronous active-high reset, bus_req, bus_lock, bus_rd, bus_wr, done and done_ok are all 0.
- R2: The operation counts as a hit exactly when ((read_word ^ cmd_cmp) & cmd_mask) == 0; done_ok is 1 on a hit and 0 on a miss.
- R3: On a hit exactly one write is issued to the same address, carrying (read_word & ~cmd_mask) | (cmd_swap & cmd_mask). The address and write data stay steady while the bus is locked.
- R4: On a miss no write cycle is issued, the target word is left unchanged, and done is given with done_ok = 0.
- R5: done_rdata carries the word read from the target, whatever the compare outcome.
- R6: bus_req rises the cycle after an accepted start and stays high until the lock is released. No read is issued before bus_gnt has been seen, and bus_lock rises only in the cycle after bus_gnt is sampled high.
- R7: bus_rd and bus_wr are only ever asserted while bus_lock is high, never both at once. Each stays high until its bus_ack is sampled.
- R8: Each operation performs exactly one read cycle, then at most one write cycle.
- R9: A cmd_start that arrives while an operation is in progress is ignored. It neither changes the result nor starts a second operation.
- R10: done is a single-cycle pulse, and bus_lock and bus_req are already low in that cycle.
- R11: With cmd_mask = 0 every operation is a hit and the value written equals the value read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse; taken only when idle |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_cmp | input | DATA_W | Compare value |
| cmd_mask | input | DATA_W | Bit mask for compare and swap |
| cmd_swap | input | DATA_W | Replacement value for masked bits |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_lock | output | 1 | Bus held for the atomic sequence |
| bus_rd | output | 1 | Read cycle request |
| bus_wr | output | 1 | Write cycle request |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | Cycle acknowledge |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | 1 when compare hit and write done |
| done_rdata | output | DATA_W | Original word read from target |

## Verification
The bench sweeps every combination of stored word, compare value and mask on a 4-bit configuration. Grant and acknowledge latencies vary from one operation to the next. A design that compared unmasked bits, or merged the wrong way round, would report the wrong done_ok or leave a wrong word in the bus model's memory. A design that wrote on a miss would be caught by the write count and the unchanged memory check. The bench also issues a second start while the first operation is running, and withholds the grant for several cycles. The first shows an engine that restarts mid-sequence; the second shows one that reads without ownership. The mask-zero cases expose a compare that treats an empty mask as a miss.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_READ    = 3'd2,
    ST_CMP     = 3'd3,
    ST_WRITE   = 3'd4,
    ST_RELEASE = 3'd5
  } cas_state_e;

endpackage

// File: rtl/cas_datapath.sv
module cas_datapath #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rd_word,
  input  logic [DATA_W-1:0] cmp_val,
  input  logic [DATA_W-1:0] mask_val,
  input  logic [DATA_W-1:0] swap_val,
  output logic              hit,
  output logic [DATA_W-1:0] merged
);

  logic [DATA_W-1:0] diff_bits;

  // Per-bit lanes: a differing bit only counts when its mask bit is set,
  // and the merged word takes the swap bit only where the mask is set.
  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    assign diff_bits[b] = (rd_word[b] ^ cmp_val[b]) & mask_val[b];
    assign merged[b]    = mask_val[b] ? swap_val[b] : rd_word[b];
  end

  assign hit = ~|diff_bits;

endmodule

// File: rtl/cas_ctrl.sv
module cas_ctrl
  import cas_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_cmp,
  input  logic [DATA_W-1:0] cmd_mask,
  input  logic [DATA_W-1:0] cmd_swap,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              hit,
  input  logic [DATA_W-1:0] merged,
  output logic              bus_req,
  output logic              bus_lock,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] cmp_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] swap_q,
  output logic              done,
  output logic              done_ok
);

  cas_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      bus_lock  <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rd_word   <= '0;
      cmp_q     <= '0;
      mask_q    <= '0;
      swap_q    <= '0;
      done      <= 1'b0;
      done_ok   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            bus_addr <= cmd_addr;
            cmp_q    <= cmd_cmp;
            mask_q   <= cmd_mask;
            swap_q   <= cmd_swap;
            bus_req  <= 1'b1;
            state    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_gnt) begin
            bus_lock <= 1'b1;
            bus_rd   <= 1'b1;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (bus_ack) begin
            bus_rd  <= 1'b0;
            rd_word <= bus_rdata;
            state   <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (hit) begin
            bus_wr    <= 1'b1;
            bus_wdata <= merged;
            state     <= ST_WRITE;
          end else begin
            bus_lock <= 1'b0;
            bus_req  <= 1'b0;
            done     <= 1'b1;
            done_ok  <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          if (bus_ack) begin
            bus_wr <= 1'b0;
            state  <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          bus_lock <= 1'b0;
          bus_req  <= 1'b0;
          done     <= 1'b1;
          done_ok  <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/masked_cas_engine.sv
module masked_cas_engine #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_cmp,
  input  logic [DATA_W-1:0] cmd_mask,
  input  logic [DATA_W-1:0] cmd_swap,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_lock,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              done,
  output logic              done_ok,
  output logic [DATA_W-1:0] done_rdata
);

  logic [DATA_W-1:0] rd_word, cmp_q, mask_q, swap_q, merged;
  logic              hit;

  cas_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_start (cmd_start),
    .cmd_addr  (cmd_addr),
    .cmd_cmp   (cmd_cmp),
    .cmd_mask  (cmd_mask),
    .cmd_swap  (cmd_swap),
    .bus_gnt   (bus_gnt),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .hit       (hit),
    .merged    (merged),
    .bus_req   (bus_req),
    .bus_lock  (bus_lock),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_word   (rd_word),
    .cmp_q     (cmp_q),
    .mask_q    (mask_q),
    .swap_q    (swap_q),
    .done      (done),
    .done_ok   (done_ok)
  );

  cas_datapath #(.DATA_W(DATA_W)) u_dp (
    .rd_word  (rd_word),
    .cmp_val  (cmp_q),
    .mask_val (mask_q),
    .swap_val (swap_q),
    .hit      (hit),
    .merged   (merged)
  );

  assign done_rdata = rd_word;

endmodule

module masked_cas_engine_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_lock,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              done
);

  // R7
  access_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> bus_lock);

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_ack) |=> bus_rd);

  // R6
  lock_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_lock) |-> $past(bus_gnt));

  // R6
  lock_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_lock |-> bus_req);

  // R3
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_lock && $past(bus_lock)) |-> $stable(bus_addr));

  // R3
  wdata_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && $past(bus_wr)) |-> $stable(bus_wdata));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_lock && !bus_req));

endmodule

bind masked_cas_engine masked_cas_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_lock  (bus_lock),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_ack   (bus_ack),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .done      (done)
);

// File: tb/masked_cas_engine_tb.sv
module masked_cas_engine_tb;

  localparam int DW = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_start = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_cmp = '0, cmd_mask = '0, cmd_swap = '0;
  logic          bus_req, bus_lock, bus_rd, bus_wr;
  logic          bus_gnt = 1'b0, bus_ack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          done, done_ok;
  logic [DW-1:0] done_rdata;

  int tests = 0, fails = 0;
  int gnt_dly = 0, ack_dly = 0, gcnt = 0, acnt = 0;
  int n_rd = 0, n_wr = 0;
  logic [DW-1:0] mem [2**AW];

  always #5 clk = ~clk;

  masked_cas_engine #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_cmp(cmd_cmp), .cmd_mask(cmd_mask), .cmd_swap(cmd_swap),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_lock(bus_lock),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .done(done), .done_ok(done_ok), .done_rdata(done_rdata)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bus slave and arbiter model, driven at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (!bus_req) begin
        bus_gnt = 1'b0; gcnt = 0;
      end else if (!bus_gnt) begin
        if (gcnt >= gnt_dly) bus_gnt = 1'b1; else gcnt++;
      end
      if ((bus_rd || bus_wr) && !bus_lock)
        chk(1'b0, "R7", int'(bus_lock), 1);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_rd || bus_wr) begin
        if (acnt >= ack_dly) begin
          bus_ack = 1'b1; acnt = 0;
          if (bus_rd) begin
            bus_rdata = mem[bus_addr]; n_rd++;
          end else begin
            mem[bus_addr] = bus_wdata; n_wr++;
          end
        end else acnt++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic run_op(input int a, input int r, input int c, input int m, input int s);
    bit seen, exp_hit;
    int exp_mem;
    mem[a] = DW'(r);
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    cmd_addr = AW'(a); cmd_cmp = DW'(c); cmd_mask = DW'(m); cmd_swap = DW'(s);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(bus_req == 1'b1, "R6", int'(bus_req), 1);
    wait_done(seen);
    exp_hit = (((r ^ c) & m) == 0);
    exp_mem = exp_hit ? (((r & ~m) | (s & m)) & 15) : r;
    chk(seen, "R10", int'(seen), 1);
    chk(done_ok == exp_hit, (m == 0) ? "R11" : "R2", int'(done_ok), int'(exp_hit));
    chk(done_rdata == DW'(r), "R5", int'(done_rdata), r);
    chk(int'(mem[a]) == exp_mem, exp_hit ? "R3" : "R4", int'(mem[a]), exp_mem);
    chk(n_rd == 1 && n_wr == int'(exp_hit), "R8", n_rd * 10 + n_wr, 10 + int'(exp_hit));
    chk(!bus_lock && !bus_req, "R10", int'(bus_lock), 0);
    @(negedge clk);
    chk(!done, "R10", int'(done), 0);
  endtask

  initial begin
    bit seen;
    for (int i = 0; i < 2**AW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_req && !bus_lock && !bus_rd && !bus_wr && !done && !done_ok, "R1",
        int'({bus_req, bus_lock, bus_rd, bus_wr, done, done_ok}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !bus_lock && !done, "R1", int'({bus_req, bus_lock, done}), 0);

    // R6: grant withheld, no read issued
    gnt_dly = 6; ack_dly = 0;
    mem[3] = 4'h9;
    cmd_addr = 4'd3; cmd_cmp = 4'h9; cmd_mask = 4'hF; cmd_swap = 4'h2;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(!bus_rd && !bus_lock && bus_req, "R6", int'({bus_rd, bus_lock, bus_req}), 1);
      @(negedge clk);
    end
    wait_done(seen);
    chk(seen && done_ok && mem[3] == 4'h2, "R6", int'(mem[3]), 2);

    // R9: second start while busy is ignored
    gnt_dly = 2; ack_dly = 1;
    mem[5] = 4'h6; mem[7] = 4'hA; n_rd = 0; n_wr = 0;
    @(negedge clk);
    cmd_addr = 4'd5; cmd_cmp = 4'h6; cmd_mask = 4'hF; cmd_swap = 4'h1;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_addr = 4'd7; cmd_cmp = 4'hA; cmd_mask = 4'hF; cmd_swap = 4'h3;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_done(seen);
    chk(seen && done_rdata == 4'h6, "R9", int'(done_rdata), 6);
    chk(mem[7] == 4'hA && mem[5] == 4'h1, "R9", int'(mem[7]), 10);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done || bus_req) seen = 1'b1;
    end
    chk(!seen && n_rd == 1, "R9", n_rd, 1);

    // Near-exhaustive sweep: every stored word, compare value and mask
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        for (int m = 0; m < 16; m++) begin
          gnt_dly = m % 3;
          ack_dly = c % 2;
          run_op((r + c) & 15, r, c, m, (r * 5 + c * 3 + m) & 15);
        end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule